// File: doc/BRIEF.md
# Fused Multiply-Add Alignment, Sum and Normalise Stage

This block is the middle of a fused multiply-add datapath. It receives a product that has already been formed and reduced to a significand with three extra low bits (guard, round and a sticky bit), together with that product's exponent and sign. It also receives the addend ("accumulator") operand as a plain significand with hidden bit, exponent and sign. The block lines the two operands up on a common exponent and then adds or subtracts them. It normalises the result so that the top significand bit is set, and hands an unrounded sign, exponent and significand to a separate rounding and packing stage.

The stage keeps every discarded bit in a sticky bit, so the later rounder can still round correctly. It covers three cases: the alignment shift, the one-bit shift after an addition carries out, and a long alignment that pushes an operand completely out of range. When the operands cancel exactly, the block raises a zero flag. A two-bit rounding-mode input then chooses the sign of that zero. The stage is a two-deep pipeline: alignment and the add/subtract fill the first register, and the leading-zero count and normalising shift fill the second. It accepts one operation per cycle.

Operands are assumed to be nonzero and normalised on entry: the product significand has its top bit set and the accumulator significand has its hidden bit set. Exponents are signed two's complement values.

Top module: `fma_sum_normalize`

## Requirements
- R1: After reset `out_valid` is low. A cycle with `in_valid` high produces `out_valid` high exactly two clock edges later, and a cycle with `in_valid` low produces `out_valid` low two edges later.
- R2: Before alignment, the accumulator significand is extended by three zero bits at the bottom. Its aligned value is `acc_sig * 8`, on the same scale as the `SIG_W`-bit product significand.
- R3: The operand with the smaller exponent is shifted right by the exponent difference. Any one bits that fall off the bottom are ORed into bit 0 of the shifted value. The result exponent before normalisation is the larger of the two input exponents.
- R4: When the exponent difference is `SIG_W` or more, the shifted operand becomes 1 if it was nonzero.
- R5: When the two signs are equal, the aligned significands are added. If the sum carries out of bit `SIG_W-1`, it is shifted right by one with the dropped bit ORed into bit 0, and the exponent rises by one.
- R6: When the signs differ, the smaller aligned magnitude is subtracted from the larger, and `out_sign` is the sign of the operand with the larger aligned magnitude.
- R7: An exact-zero difference sets `out_zero`, with `out_sig` = 0 and `out_exp` = 0. `out_sign` is 1 only when `round_mode` is 2'b11 (toward minus infinity). The other codes are 2'b00 nearest-even, 2'b01 toward zero and 2'b10 toward plus infinity, and each gives a positive zero.
- R8: A nonzero result leaves with bit `SIG_W-1` of `out_sig` set. The exponent is reduced by the number of places the significand was shifted left to get there.
- R9: Exponents are signed `EXP_W`-bit values. Negative input exponents and results that fall below zero are carried without wrap-around, provided the inputs keep at least a few counts away from the ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously by the caller |
| in_valid | input | 1 | Operands on the inputs are to be processed this cycle |
| prod_sign | input | 1 | Product sign, 1 = negative |
| prod_exp | input | EXP_W | Product exponent, signed |
| prod_sig | input | SIG_W | Product significand with guard, round and sticky bits |
| acc_sign | input | 1 | Accumulator sign, 1 = negative |
| acc_exp | input | EXP_W | Accumulator exponent, signed |
| acc_sig | input | MAN_W | Accumulator significand including hidden bit |
| round_mode | input | 2 | Rounding mode, used only for the sign of an exact zero |
| out_valid | output | 1 | Result on the outputs is valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent, signed, unrounded |
| out_sig | output | SIG_W | Normalised unrounded significand |
| out_zero | output | 1 | Result is an exact zero from cancellation |

## Verification
The bench uses a narrow configuration with a 5-bit accumulator significand and an 8-bit product significand. It sweeps many product significands, all accumulator significands, exponent gaps from -10 to +10 around a negative base, both sign relations and all rounding modes, and checks each result against an integer model. Several failures would show up in the sweep:
- A design that drops the sticky bit on alignment or on carry-out would give an even significand where an odd one is expected.
- An alignment shifter that wraps or saturates wrongly on gaps of 8 or more would give garbage instead of a lone sticky bit.
- Choosing the sign from the wrong operand under subtraction would flip the sign whenever the product is the larger.
- Exact-cancellation cases with mode 2'b11 would expose a zero whose sign ignores the rounding mode.
- An off-by-one leading-zero count would break the normalised top bit and shift the exponent.

// File: rtl/fsn_pkg.sv
package fsn_pkg;
  // Rounding-mode codes. Only the toward-minus-infinity code changes behaviour here.
  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ZERO    = 2'b01,
    RND_UP      = 2'b10,
    RND_DOWN    = 2'b11
  } rnd_mode_e;

  localparam int unsigned GRS_W = 3;  // guard, round, sticky
endpackage

// File: rtl/sticky_rshift.sv
// Right shift that ORs every discarded one bit into bit 0 of the result.
// An amount of W or more returns only the sticky bit.
module sticky_rshift #(
  parameter int unsigned W    = 27,
  parameter int unsigned SH_W = $clog2(W + 1)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  output logic [W-1:0]    dout
);
  logic [W-1:0] lost_mask;
  logic         lost;

  always_comb begin
    lost_mask = ~({W{1'b1}} << amt);
    lost      = |(din & lost_mask);
    dout      = (din >> amt) | {{(W-1){1'b0}}, lost};
  end
endmodule

// File: rtl/align_add.sv
// Exponent compare, sticky alignment and signed-magnitude add/subtract.
module align_add
  import fsn_pkg::*;
#(
  parameter int unsigned MAN_W = 24,
  parameter int unsigned EXP_W = 10,
  localparam int unsigned SIG_W = MAN_W + GRS_W,
  localparam int unsigned SH_W  = $clog2(SIG_W + 1)
) (
  input  logic                    prod_sign,
  input  logic signed [EXP_W-1:0] prod_exp,
  input  logic [SIG_W-1:0]        prod_sig,
  input  logic                    acc_sign,
  input  logic signed [EXP_W-1:0] acc_exp,
  input  logic [MAN_W-1:0]        acc_sig,
  input  logic [1:0]              round_mode,
  output logic                    sum_sign,
  output logic signed [EXP_W-1:0] sum_exp,
  output logic [SIG_W-1:0]        sum_sig,
  output logic                    sum_zero
);
  logic signed [EXP_W:0] ediff;
  logic [EXP_W:0]        gap;
  logic                  acc_bigger;
  logic [SH_W-1:0]       amt, prod_amt, acc_amt;
  logic [SIG_W-1:0]      acc_ext, prod_al, acc_al;
  logic signed [EXP_W-1:0] big_exp;
  logic [SIG_W:0]        wide;
  logic                  acc_ge;

  assign acc_ext = {acc_sig, {GRS_W{1'b0}}};

  always_comb begin
    ediff      = {acc_exp[EXP_W-1], acc_exp} - {prod_exp[EXP_W-1], prod_exp};
    acc_bigger = ediff > 0;
    gap        = acc_bigger ? ediff : -ediff;
    if (gap >= (EXP_W+1)'(SIG_W)) amt = SH_W'(SIG_W);
    else                          amt = gap[SH_W-1:0];
    prod_amt = acc_bigger ? amt : '0;
    acc_amt  = acc_bigger ? '0  : amt;
    big_exp  = acc_bigger ? acc_exp : prod_exp;
  end

  sticky_rshift #(.W(SIG_W), .SH_W(SH_W)) u_prod_shift (
    .din(prod_sig), .amt(prod_amt), .dout(prod_al));
  sticky_rshift #(.W(SIG_W), .SH_W(SH_W)) u_acc_shift (
    .din(acc_ext), .amt(acc_amt), .dout(acc_al));

  always_comb begin
    acc_ge   = acc_al >= prod_al;
    sum_zero = 1'b0;
    sum_exp  = big_exp;
    if (acc_sign == prod_sign) begin
      wide     = {1'b0, acc_al} + {1'b0, prod_al};
      sum_sign = acc_sign;
      if (wide[SIG_W]) begin
        sum_sig = wide[SIG_W:1] | {{(SIG_W-1){1'b0}}, wide[0]};
        sum_exp = big_exp + EXP_W'(1);
      end else begin
        sum_sig = wide[SIG_W-1:0];
      end
    end else begin
      wide     = '0;
      sum_sig  = acc_ge ? (acc_al - prod_al) : (prod_al - acc_al);
      sum_sign = acc_ge ? acc_sign : prod_sign;
      if (sum_sig == '0) begin
        sum_zero = 1'b1;
        sum_sign = (round_mode == RND_DOWN);
      end
    end
  end
endmodule

// File: rtl/lead_norm.sv
// Leading-zero count and left shift that brings the top bit to SIG_W-1.
module lead_norm #(
  parameter int unsigned SIG_W = 27,
  parameter int unsigned EXP_W = 10,
  localparam int unsigned LZ_W = $clog2(SIG_W + 1)
) (
  input  logic [SIG_W-1:0]        din,
  input  logic signed [EXP_W-1:0] exp_in,
  output logic [SIG_W-1:0]        dout,
  output logic signed [EXP_W-1:0] exp_out
);
  logic [LZ_W-1:0] lz;
  logic            found;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (din[i]) found = 1'b1;
        else        lz    = lz + LZ_W'(1);
      end
    end
    dout    = din << lz;
    exp_out = exp_in - EXP_W'(lz);
  end
endmodule

// File: rtl/fma_sum_normalize.sv
module fma_sum_normalize
  import fsn_pkg::*;
#(
  parameter int unsigned MAN_W = 24,
  parameter int unsigned EXP_W = 10,
  localparam int unsigned SIG_W = MAN_W + GRS_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    prod_sign,
  input  logic signed [EXP_W-1:0] prod_exp,
  input  logic [SIG_W-1:0]        prod_sig,
  input  logic                    acc_sign,
  input  logic signed [EXP_W-1:0] acc_exp,
  input  logic [MAN_W-1:0]        acc_sig,
  input  logic [1:0]              round_mode,
  output logic                    out_valid,
  output logic                    out_sign,
  output logic signed [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0]        out_sig,
  output logic                    out_zero
);
  // ---------------- stage 1: align and add ----------------
  logic                    a_sign, a_zero;
  logic signed [EXP_W-1:0] a_exp;
  logic [SIG_W-1:0]        a_sig;

  align_add #(.MAN_W(MAN_W), .EXP_W(EXP_W)) u_align_add (
    .prod_sign(prod_sign), .prod_exp(prod_exp), .prod_sig(prod_sig),
    .acc_sign(acc_sign),   .acc_exp(acc_exp),   .acc_sig(acc_sig),
    .round_mode(round_mode),
    .sum_sign(a_sign), .sum_exp(a_exp), .sum_sig(a_sig), .sum_zero(a_zero));

  logic                    s1_valid, s1_sign, s1_zero;
  logic signed [EXP_W-1:0] s1_exp;
  logic [SIG_W-1:0]        s1_sig;
  logic                    s1_en;

  always_comb s1_en = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_zero  <= 1'b0;
      s1_exp   <= '0;
      s1_sig   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (s1_en) begin
        s1_sign <= a_sign;
        s1_zero <= a_zero;
        s1_exp  <= a_exp;
        s1_sig  <= a_sig;
      end
    end
  end

  // Larger input exponent, formed apart from the aligner for checking.
  logic signed [EXP_W-1:0] exp_max;
  always_comb exp_max = (acc_exp > prod_exp) ? acc_exp : prod_exp;

  // R3 R5
  align_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (s1_zero || s1_exp == $past(exp_max) ||
                  s1_exp == $past(exp_max) + EXP_W'(1)));

  // ---------------- stage 2: normalise ----------------
  logic [SIG_W-1:0]        n_sig;
  logic signed [EXP_W-1:0] n_exp;

  lead_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_norm (
    .din(s1_sig), .exp_in(s1_exp), .dout(n_sig), .exp_out(n_exp));

  logic                    o_sign_d, o_zero_d;
  logic signed [EXP_W-1:0] o_exp_d;
  logic [SIG_W-1:0]        o_sig_d;
  logic                    o_en;

  always_comb begin
    o_en     = s1_valid;
    o_sign_d = s1_sign;
    o_zero_d = s1_zero;
    o_exp_d  = s1_zero ? '0 : n_exp;
    o_sig_d  = s1_zero ? '0 : n_sig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_zero  <= 1'b0;
      out_exp   <= '0;
      out_sig   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (o_en) begin
        out_sign <= o_sign_d;
        out_zero <= o_zero_d;
        out_exp  <= o_exp_d;
        out_sig  <= o_sig_d;
      end
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R1
  idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ##1 !out_valid);

  // R8
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_zero) |-> out_sig[SIG_W-1]);

  // R7
  zero_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_zero) |->
      (out_sig == '0 && out_sign == ($past(round_mode, 2) == RND_DOWN)));
endmodule

// File: tb/fma_sum_normalize_test.sv
`timescale 1ns/1ps
module fma_sum_normalize_test;
  localparam int MAN_W = 5;
  localparam int EXP_W = 10;
  localparam int SIG_W = MAN_W + 3;

  logic clk, rst_n, in_valid;
  logic prod_sign, acc_sign;
  logic signed [EXP_W-1:0] prod_exp, acc_exp;
  logic [SIG_W-1:0] prod_sig;
  logic [MAN_W-1:0] acc_sig;
  logic [1:0] round_mode;
  logic out_valid, out_sign, out_zero;
  logic signed [EXP_W-1:0] out_exp;
  logic [SIG_W-1:0] out_sig;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  fma_sum_normalize #(.MAN_W(MAN_W), .EXP_W(EXP_W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .prod_sign(prod_sign), .prod_exp(prod_exp), .prod_sig(prod_sig),
    .acc_sign(acc_sign), .acc_exp(acc_exp), .acc_sig(acc_sig),
    .round_mode(round_mode),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_sig(out_sig), .out_zero(out_zero));

  initial clk = 0;
  always #10 clk = ~clk;  // 50 MHz

  // Sticky right shift on integers: shifted-out ones land in bit 0.
  function automatic int srs(int v, int s);
    if (s >= SIG_W) return (v != 0) ? 1 : 0;
    return (v >> s) | (((v % (1 << s)) != 0) ? 1 : 0);
  endfunction

  task automatic check1(string tag, bit ok, string got, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got %s expected %s", tag, got, exp);
    end
  endtask

  task automatic run_op(bit ps, int pe, int psig, bit as, int ae, int asig,
                        int rm, bit chk_latency);
    int z, r, e, s, sum, d, xs, xe, xsig;
    bit xzero;
    string tag;
    // reference model
    z = asig * 8;           // R2
    r = psig;
    tag = "R2 R3 R9";
    if (ae > pe) begin s = ae - pe; r = srs(r, s); e = ae; end
    else begin s = pe - ae; z = srs(z, s); e = pe; end
    if (s >= SIG_W) tag = "R4";
    xzero = 0;
    if (ps == as) begin
      sum = z + r; xs = as;
      if (sum >= (1 << SIG_W)) begin
        sum = (sum >> 1) | (sum & 1); e++; tag = "R5";
      end
      xsig = sum; xe = e;
    end else begin
      tag = (tag == "R4") ? "R4 R6" : "R6 R8";
      if (z >= r) begin d = z - r; xs = as; end
      else begin d = r - z; xs = ps; end
      if (d == 0) begin
        xzero = 1; xs = (rm == 3); xsig = 0; xe = 0; tag = "R7";
      end else begin
        while (d < (1 << (SIG_W - 1))) begin d = d << 1; e--; end
        xsig = d; xe = e;
      end
    end
    // drive
    @(negedge clk);
    in_valid = 1; prod_sign = ps; prod_exp = EXP_W'(pe); prod_sig = SIG_W'(psig);
    acc_sign = as; acc_exp = EXP_W'(ae); acc_sig = MAN_W'(asig);
    round_mode = 2'(rm);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    if (chk_latency)
      check1("R1 early", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");
    @(posedge clk);
    @(negedge clk);
    check1(tag,
      out_valid && out_zero == xzero && out_sign == xs &&
      int'(out_exp) == xe && int'(out_sig) == xsig,
      $sformatf("v=%0b z=%0b s=%0b e=%0d sig=%0d", out_valid, out_zero,
                out_sign, int'(out_exp), int'(out_sig)),
      $sformatf("v=1 z=%0b s=%0b e=%0d sig=%0d", xzero, xs, xe, xsig));
  endtask

  initial begin
    int k;
    rst_n = 0; in_valid = 0; prod_sign = 0; acc_sign = 0;
    prod_exp = '0; acc_exp = '0; prod_sig = '0; acc_sig = '0; round_mode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check1("R1 reset", out_valid == 1'b0, $sformatf("%0b", out_valid), "0");

    // directed corners
    run_op(0, 2, 128, 0, 2, 16, 0, 1);    // R1 latency, R5 carry
    run_op(0, 0, 128, 1, 0, 16, 3, 0);    // R7 zero, mode down -> negative
    run_op(1, 0, 128, 0, 0, 16, 0, 0);    // R7 zero, nearest -> positive
    run_op(1, 0, 128, 0, 0, 16, 2, 0);    // R7 zero, up -> positive
    run_op(0, -20, 255, 0, 0, 16, 0, 0);  // R4 collapse to sticky
    run_op(1, 0, 255, 0, 8, 31, 1, 0);    // R4 gap equals SIG_W
    run_op(1, -7, 129, 0, -7, 17, 0, 0);  // R6 R8 deep cancellation, R9
    run_op(0, 3, 200, 1, 1, 31, 0, 0);    // R6 product larger

    // sweep
    k = 0;
    for (int ps = 128; ps < 256; ps += 5) begin
      for (int as = 16; as < 32; as++) begin
        for (int dgap = -10; dgap <= 10; dgap++) begin
          for (int sg = 0; sg < 2; sg++) begin
            run_op(bit'(k % 2), -3, ps, bit'((k % 2) ^ sg), -3 + dgap, as,
                   (k / 2) % 4, 0);
            k++;
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog got timeout expected completion");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule